// File: doc/BRIEF.md
# DDR2 Clock-Enable Power-Down Sequencer

This block sits beside a DDR2 memory controller's command scheduler and decides when the memory's clock-enable line may be pulled low to put the device into power-down, and when it has to come back up. It watches the commands the controller issues, the open-row flags of the banks, a burst-in-flight flag and a write-recovery flag from the host. It also watches a refresh-due request and a request line from the scheduler that wants the command bus. From these inputs it drives the clock-enable output. It forces NOP onto the command bus for as long as the line is low and for a programmable settling time after it returns. It also reports whether the current power-down is the precharge kind (no bank open) or the active kind (a row open somewhere).

Entry is tried only after a programmable run of quiet cycles. It is refused while a read or write burst or its recovery window is still running, while a mode-register write is inside its hold-off time, and while the memory has not yet spent the minimum time awake. Once entered, the line stays low for at least the minimum pulse width. It then rises when the scheduler asks for the bus, when a refresh falls due, or when the maximum dwell time runs out. The scheduler gets its grant only once the post-exit delay has passed. All timings are cycle counts taken from configuration inputs.

Top module: `ckeGate`

## Requirements
- R1: While reset is held and on the first cycle after it, ckeOut is 1, forceNop is 0 and schedAck is 0.
- R2: cmdType encodes NOP=0, ACT=1, READ=2, WRITE=3, PRE=4, REF=5, MRS=6, DES=7. A quiet cycle has no command other than NOP or DES, and has burstBusy, recovBusy, schedReq and refreshDue all low. ckeOut falls after cfgIdle+1 consecutive quiet cycles. Any other command during the countdown restarts it.
- R3: While burstBusy or recovBusy is high, ckeOut never falls. Entry comes cfgIdle+1 cycles after both have dropped.
- R4: A mode-register write (MRS, code 6) blocks entry for the following cfgModeHold cycles, so entry comes cfgModeHold+cfgIdle+1 cycles after the MRS cycle.
- R5: forceNop is 1 on every cycle in which ckeOut is 0, including the first one.
- R6: pdKind is 1 when any bit of bankOpen was set on the cycle before ckeOut fell, and 0 otherwise. It holds its value until the next entry, whatever bankOpen does meanwhile.
- R7: With schedReq high throughout power-down, ckeOut stays low for exactly cfgCkeMin cycles (cfgCkeMin at least 1), and never fewer.
- R8: With no other wake source, ckeOut stays low for max(cfgCkeMin, cfgMaxDwell) cycles. A refreshDue first seen on low cycle k ends power-down after max(k, cfgCkeMin) low cycles, and refreshDue high prevents entry.
- R9: After ckeOut rises, forceNop stays 1 and schedAck stays 0 for max(1, cfgExitDelay) cycles.
- R10: ckeOut stays high for at least cfgCkeMin cycles between power-downs. With no activity it falls after e + max(cfgIdle+1, cfgCkeMin-e+1) high cycles, where e = max(1, cfgExitDelay).
- R11: schedAck equals schedReq when the block is awake and settled, and is 0 otherwise. A schedReq arriving on the cycle the idle countdown would complete cancels the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | A command is issued this cycle |
| cmdType | input | 3 | Command code (see R2) |
| bankOpen | input | NUM_BANKS | One flag per bank, set while a row is open |
| burstBusy | input | 1 | Read or write burst in flight, through its postamble |
| recovBusy | input | 1 | Write-recovery / write-to-read window still running |
| schedReq | input | 1 | Scheduler wants to issue commands |
| refreshDue | input | 1 | A refresh must be issued soon |
| cfgIdle | input | CNT_W | Quiet cycles required before entry |
| cfgCkeMin | input | CNT_W | Minimum clock-enable low and high width |
| cfgMaxDwell | input | CNT_W | Longest allowed power-down in cycles |
| cfgExitDelay | input | CNT_W | Settling cycles after exit before the grant |
| cfgModeHold | input | CNT_W | Entry hold-off after a mode-register write |
| ckeOut | output | 1 | Clock-enable to the memory |
| forceNop | output | 1 | Command bus must carry NOP/DESELECT |
| schedAck | output | 1 | Grant to the scheduler |
| pdKind | output | 1 | 1 = active power-down, 0 = precharge power-down |

## Verification
Two pairs of functions can fall in the same cycle. The first is a wake source and the minimum low width: the bench raises refreshDue on the very first low cycle while cfgCkeMin is 3. It judges that the line stays low for the full three cycles and not one fewer. The second is the completion of the idle countdown and a scheduler request: the bench raises schedReq exactly on the cycle whose sample would have triggered entry. It expects ckeOut to stay high and schedAck to follow at once. Around these collisions the bench sweeps every combination of a small range of minimum width, idle count and exit delay, and computes every expected cycle count arithmetically from the requirement formulas.

// File: rtl/ckeGatePkg.sv
package ckeGatePkg;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_ACT   = 3'd1,
    CMD_READ  = 3'd2,
    CMD_WRITE = 3'd3,
    CMD_PRE   = 3'd4,
    CMD_REF   = 3'd5,
    CMD_MRS   = 3'd6,
    CMD_DES   = 3'd7
  } cmdKindE;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_PD   = 2'd1,
    ST_EXIT = 2'd2
  } gateStateE;

  // strobes from control to datapath
  typedef struct packed {
    logic enterPd;
    logic enterExit;
    logic inRun;
    logic inPd;
  } ctrlStrobeT;

  // compare results from datapath to control
  typedef struct packed {
    logic quietNow;
    logic idleMet;
    logic highMet;
    logic minLowMet;
    logic dwellMet;
    logic exitDone;
  } dpStatusT;

endpackage

// File: rtl/ckeGateSatCnt.sv
module ckeGateSatCnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rstN)                      cnt <= '0;
    else if (clr)                   cnt <= '0;
    else if (load)                  cnt <= loadVal;
    else if (inc && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ckeGateDp.sv
module ckeGateDp
  import ckeGatePkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int NUM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobeT           strobe,
  input  logic                 cmdValid,
  input  logic [2:0]           cmdType,
  input  logic [NUM_BANKS-1:0] bankOpen,
  input  logic                 burstBusy,
  input  logic                 recovBusy,
  input  logic                 schedReq,
  input  logic                 refreshDue,
  input  logic [CNT_W-1:0]     cfgIdle,
  input  logic [CNT_W-1:0]     cfgCkeMin,
  input  logic [CNT_W-1:0]     cfgMaxDwell,
  input  logic [CNT_W-1:0]     cfgExitDelay,
  input  logic [CNT_W-1:0]     cfgModeHold,
  output dpStatusT             status,
  output logic                 pdKind
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] idleCnt, stCnt, highCnt, mrsCnt;
  logic isCmd, isMrs, mrsBusy, quiet, anyOpen;

  always_comb begin
    isCmd   = cmdValid && (cmdType != CMD_NOP) && (cmdType != CMD_DES);
    isMrs   = cmdValid && (cmdType == CMD_MRS);
    mrsBusy = (mrsCnt != '0);
    quiet   = !isCmd && !burstBusy && !recovBusy && !mrsBusy
              && !schedReq && !refreshDue;
  end

  // row-open reduction over the bank flags
  logic [NUM_BANKS:0] openChain;
  assign openChain[0] = 1'b0;
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bankOr
    assign openChain[b+1] = openChain[b] | bankOpen[b];
  end
  assign anyOpen = openChain[NUM_BANKS];

  // consecutive quiet cycles while awake and settled
  ckeGateSatCnt #(.W(CNT_W)) i_idleCnt (
    .clk(clk), .rstN(rstN),
    .clr(!quiet || !strobe.inRun), .load(1'b0), .loadVal('0), .inc(1'b1),
    .cnt(idleCnt)
  );

  // cycles spent in the current low or settling phase, shared by all windows
  ckeGateSatCnt #(.W(CNT_W)) i_stCnt (
    .clk(clk), .rstN(rstN),
    .clr(1'b0), .load(strobe.enterPd || strobe.enterExit), .loadVal(ONE), .inc(1'b1),
    .cnt(stCnt)
  );

  // cycles with clock-enable high since the last power-down
  ckeGateSatCnt #(.W(CNT_W)) i_highCnt (
    .clk(clk), .rstN(rstN),
    .clr(strobe.inPd), .load(1'b0), .loadVal('0), .inc(1'b1),
    .cnt(highCnt)
  );

  // mode-register hold-off down counter
  always_ff @(posedge clk) begin
    if (!rstN)        mrsCnt <= '0;
    else if (isMrs)   mrsCnt <= cfgModeHold;
    else if (mrsBusy) mrsCnt <= mrsCnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               pdKind <= 1'b0;
    else if (strobe.enterPd) pdKind <= anyOpen;
  end

  always_comb begin
    status.quietNow  = quiet;
    status.idleMet   = (idleCnt >= cfgIdle);
    status.highMet   = (highCnt >= cfgCkeMin);
    status.minLowMet = (stCnt >= cfgCkeMin);
    status.dwellMet  = (stCnt >= cfgMaxDwell);
    status.exitDone  = (stCnt >= cfgExitDelay);
  end
endmodule

// File: rtl/ckeGateCtrl.sv
module ckeGateCtrl
  import ckeGatePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpStatusT   status,
  input  logic       schedReq,
  input  logic       refreshDue,
  output ctrlStrobeT strobe,
  output logic       ckeOut,
  output logic       forceNop,
  output logic       schedAck
);
  gateStateE state, stateNext;

  always_comb begin
    stateNext        = state;
    strobe.enterPd   = 1'b0;
    strobe.enterExit = 1'b0;
    unique case (state)
      ST_RUN: begin
        if (status.quietNow && status.idleMet && status.highMet) begin
          stateNext      = ST_PD;
          strobe.enterPd = 1'b1;
        end
      end
      ST_PD: begin
        if (status.minLowMet && (schedReq || refreshDue || status.dwellMet)) begin
          stateNext        = ST_EXIT;
          strobe.enterExit = 1'b1;
        end
      end
      ST_EXIT: begin
        if (status.exitDone) stateNext = ST_RUN;
      end
      default: stateNext = ST_RUN;
    endcase
    strobe.inRun = (state == ST_RUN);
    strobe.inPd  = (state == ST_PD);
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end

  always_comb begin
    ckeOut   = (state != ST_PD);
    forceNop = rstN && (state != ST_RUN);
    schedAck = rstN && (state == ST_RUN) && schedReq;
  end
endmodule

// File: rtl/ckeGate.sv
module ckeGate
  import ckeGatePkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int NUM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic [2:0]           cmdType,
  input  logic [NUM_BANKS-1:0] bankOpen,
  input  logic                 burstBusy,
  input  logic                 recovBusy,
  input  logic                 schedReq,
  input  logic                 refreshDue,
  input  logic [CNT_W-1:0]     cfgIdle,
  input  logic [CNT_W-1:0]     cfgCkeMin,
  input  logic [CNT_W-1:0]     cfgMaxDwell,
  input  logic [CNT_W-1:0]     cfgExitDelay,
  input  logic [CNT_W-1:0]     cfgModeHold,
  output logic                 ckeOut,
  output logic                 forceNop,
  output logic                 schedAck,
  output logic                 pdKind
);
  ctrlStrobeT strobe;
  dpStatusT   status;

  ckeGateDp #(.CNT_W(CNT_W), .NUM_BANKS(NUM_BANKS)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cmdValid(cmdValid), .cmdType(cmdType), .bankOpen(bankOpen),
    .burstBusy(burstBusy), .recovBusy(recovBusy),
    .schedReq(schedReq), .refreshDue(refreshDue),
    .cfgIdle(cfgIdle), .cfgCkeMin(cfgCkeMin), .cfgMaxDwell(cfgMaxDwell),
    .cfgExitDelay(cfgExitDelay), .cfgModeHold(cfgModeHold),
    .status(status), .pdKind(pdKind)
  );

  ckeGateCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .status(status),
    .schedReq(schedReq), .refreshDue(refreshDue),
    .strobe(strobe), .ckeOut(ckeOut), .forceNop(forceNop), .schedAck(schedAck)
  );
endmodule

// File: rtl/ckeGateChk.sv
module ckeGateChk
  import ckeGatePkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdValid,
  input logic [2:0]       cmdType,
  input logic             burstBusy,
  input logic             recovBusy,
  input logic             refreshDue,
  input logic [CNT_W-1:0] cfgCkeMin,
  input logic             ckeOut,
  input logic             forceNop,
  input logic             schedAck,
  input logic             pdKind
);
  localparam logic [CNT_W:0] LEN_MAX = '1;
  logic [CNT_W:0] lowLen, highLen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowLen  <= '0;
      highLen <= '0;
    end else if (ckeOut) begin
      lowLen  <= '0;
      if (highLen != LEN_MAX) highLen <= highLen + 1'b1;
    end else begin
      highLen <= '0;
      if (lowLen != LEN_MAX) lowLen <= lowLen + 1'b1;
    end
  end

  assert_entry_idle_bus_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ckeOut) |-> $past(!burstBusy && !recovBusy));

  assert_entry_no_mrs_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ckeOut) |-> $past(!(cmdValid && cmdType == CMD_MRS)));

  assert_low_forces_nop_R5: assert property (@(posedge clk) disable iff (!rstN)
    !ckeOut |-> forceNop);

  assert_kind_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!ckeOut && $past(!ckeOut)) |-> $stable(pdKind));

  assert_min_low_width_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ckeOut) |-> (lowLen >= {1'b0, cfgCkeMin}));

  assert_no_entry_refresh_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ckeOut) |-> $past(!refreshDue));

  assert_min_high_width_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ckeOut) |-> (highLen >= {1'b0, cfgCkeMin}));

  assert_grant_gated_R11: assert property (@(posedge clk) disable iff (!rstN)
    schedAck |-> (ckeOut && !forceNop));
endmodule

bind ckeGate ckeGateChk #(.CNT_W(CNT_W)) i_ckeGateChk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdType(cmdType),
  .burstBusy(burstBusy), .recovBusy(recovBusy), .refreshDue(refreshDue),
  .cfgCkeMin(cfgCkeMin), .ckeOut(ckeOut), .forceNop(forceNop),
  .schedAck(schedAck), .pdKind(pdKind)
);

// File: tb/test_ckeGate.sv
module test_ckeGate;
  localparam int CNT_W = 8;
  localparam int NB    = 4;

  logic clk = 1'b0;
  logic rstN;
  logic cmdValid;
  logic [2:0] cmdType;
  logic [NB-1:0] bankOpen;
  logic burstBusy, recovBusy, schedReq, refreshDue;
  logic [CNT_W-1:0] cfgIdle, cfgCkeMin, cfgMaxDwell, cfgExitDelay, cfgModeHold;
  logic ckeOut, forceNop, schedAck, pdKind;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  ckeGate #(.CNT_W(CNT_W), .NUM_BANKS(NB)) i_ckeGate (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdType(cmdType),
    .bankOpen(bankOpen), .burstBusy(burstBusy), .recovBusy(recovBusy),
    .schedReq(schedReq), .refreshDue(refreshDue),
    .cfgIdle(cfgIdle), .cfgCkeMin(cfgCkeMin), .cfgMaxDwell(cfgMaxDwell),
    .cfgExitDelay(cfgExitDelay), .cfgModeHold(cfgModeHold),
    .ckeOut(ckeOut), .forceNop(forceNop), .schedAck(schedAck), .pdKind(pdKind)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic waitCke(input logic lvl, output int n);
    n = 0;
    do begin
      tick();
      n++;
    end while (ckeOut !== lvl && n < 2000);
  endtask

  task automatic waitAck(output int n);
    n = 0;
    while (schedAck !== 1'b1 && n < 2000) begin
      tick();
      n++;
    end
  endtask

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // bring the block back to an awake, settled state with schedReq held
  task automatic settle();
    int n;
    schedReq = 1'b1;
    if (ckeOut !== 1'b1) waitCke(1'b1, n);
    waitAck(n);
    repeat (8) tick();
  endtask

  initial begin
    #(8 * 190000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    int n, e, kindExp;
    rstN = 1'b0; cmdValid = 1'b0; cmdType = 3'd0; bankOpen = '0;
    burstBusy = 1'b0; recovBusy = 1'b0; schedReq = 1'b0; refreshDue = 1'b0;
    cfgIdle = 8'd1; cfgCkeMin = 8'd2; cfgMaxDwell = 8'd200;
    cfgExitDelay = 8'd1; cfgModeHold = 8'd0;
    repeat (4) tick();
    check("R1 cke in reset", int'(ckeOut), 1);
    check("R1 forceNop in reset", int'(forceNop), 0);
    check("R1 schedAck in reset", int'(schedAck), 0);
    rstN = 1'b1;
    schedReq = 1'b1;
    tick();
    check("R1 cke after reset", int'(ckeOut), 1);
    check("R1 forceNop after reset", int'(forceNop), 0);
    repeat (8) tick();
    check("R11 ack follows req", int'(schedAck), 1);

    // sweep: entry delay, low width, kind, exit window
    for (int ck = 1; ck <= 3; ck++) begin
      for (int id = 0; id <= 2; id++) begin
        for (int ed = 0; ed <= 2; ed++) begin
          cfgCkeMin = 8'(ck); cfgIdle = 8'(id); cfgExitDelay = 8'(ed);
          kindExp = (ck + id + ed) % 2;
          bankOpen = (kindExp == 1) ? 4'b0100 : 4'b0000;
          settle();
          schedReq = 1'b0;
          waitCke(1'b0, n);
          check("R2 entry after idle count", n, id + 1);
          check("R5 nop on first low cycle", int'(forceNop), 1);
          check("R6 kind at entry", int'(pdKind), kindExp);
          bankOpen = ~bankOpen;
          schedReq = 1'b1;
          waitCke(1'b1, n);
          check("R7 low width on request", n, ck);
          check("R6 kind held through power-down", int'(pdKind), kindExp);
          check("R9 nop held after exit", int'(forceNop), 1);
          check("R9 no grant right after exit", int'(schedAck), 0);
          waitAck(n);
          check("R9 exit window", n, maxOf(1, ed));
        end
      end
    end

    // minimum high width and idle re-entry
    for (int ck = 1; ck <= 4; ck++) begin
      for (int id = 0; id <= 1; id++) begin
        for (int ed = 0; ed <= 2; ed++) begin
          cfgCkeMin = 8'(ck); cfgIdle = 8'(id); cfgExitDelay = 8'(ed);
          settle();
          schedReq = 1'b0;
          waitCke(1'b0, n);
          schedReq = 1'b1;
          waitCke(1'b1, n);
          schedReq = 1'b0;
          waitCke(1'b0, n);
          e = maxOf(1, ed);
          check("R10 high width before re-entry", n, e + maxOf(id + 1, ck - e + 1));
        end
      end
    end

    // bursts and recovery windows block entry
    cfgCkeMin = 8'd2; cfgIdle = 8'd2; cfgExitDelay = 8'd1;
    for (int which = 0; which < 2; which++) begin
      settle();
      schedReq = 1'b0;
      if (which == 0) burstBusy = 1'b1; else recovBusy = 1'b1;
      n = 0;
      repeat (30) begin
        tick();
        if (ckeOut !== 1'b1) n++;
      end
      check("R3 no entry while busy", n, 0);
      burstBusy = 1'b0; recovBusy = 1'b0;
      waitCke(1'b0, n);
      check("R3 entry after busy clears", n, 3);
    end

    // a command during the countdown restarts it; NOP/DES do not
    settle();
    schedReq = 1'b0;
    tick();
    cmdValid = 1'b1; cmdType = 3'd2;
    tick();
    check("R2 READ keeps cke high", int'(ckeOut), 1);
    cmdValid = 1'b0;
    waitCke(1'b0, n);
    check("R2 restart after READ", n, 3);
    settle();
    cmdValid = 1'b1; cmdType = 3'd7;
    schedReq = 1'b0;
    waitCke(1'b0, n);
    check("R2 DES counts as quiet", n, 3);
    cmdType = 3'd0;
    settle();
    schedReq = 1'b0;
    waitCke(1'b0, n);
    check("R2 NOP counts as quiet", n, 3);
    cmdValid = 1'b0;

    // mode-register hold-off
    for (int m = 0; m <= 4; m++) begin
      cfgModeHold = 8'(m);
      settle();
      schedReq = 1'b0;
      cmdValid = 1'b1; cmdType = 3'd6;
      tick();
      cmdValid = 1'b0; cmdType = 3'd0;
      waitCke(1'b0, n);
      check("R4 entry after MRS hold", n, m + 2 + 1);
    end
    cfgModeHold = 8'd0;

    // maximum dwell
    for (int d = 1; d <= 6; d += 5) begin
      cfgMaxDwell = 8'(d);
      settle();
      schedReq = 1'b0;
      waitCke(1'b0, n);
      waitCke(1'b1, n);
      schedReq = 1'b1;
      check("R8 dwell limit", n, maxOf(2, d));
    end
    cfgMaxDwell = 8'd200;

    // refresh forces exit, late and on the first low cycle
    settle();
    schedReq = 1'b0;
    waitCke(1'b0, n);
    repeat (3) tick();
    refreshDue = 1'b1;
    waitCke(1'b1, n);
    check("R8 refresh exit after 4 low cycles", n + 3, 4);
    n = 0;
    repeat (20) begin
      tick();
      if (ckeOut !== 1'b1) n++;
    end
    check("R8 refresh blocks entry", n, 0);
    refreshDue = 1'b0;
    cfgCkeMin = 8'd3;
    settle();
    schedReq = 1'b0;
    waitCke(1'b0, n);
    refreshDue = 1'b1;
    waitCke(1'b1, n);
    check("R8 refresh respects min width", n, 3);
    refreshDue = 1'b0;

    // request on the cycle the countdown would complete
    cfgIdle = 8'd2;
    settle();
    schedReq = 1'b0;
    tick();
    tick();
    schedReq = 1'b1;
    #1;
    check("R11 grant on collision cycle", int'(schedAck), 1);
    tick();
    check("R11 collision cancels entry", int'(ckeOut), 1);
    check("R11 grant held", int'(schedAck), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule